// File: doc/BRIEF.md
# Processor Status Register and Flag Update Unit

This block holds the eight condition and control flags of an 8-bit processor core and computes their next values each cycle. It takes the operands and result of an ALU operation together with a per-flag update mask, derives half carry, overflow, negative, zero and carry for the kind of operation, and merges only the masked flags into the register. The sign flag is never stored on its own: it is recomputed as negative xor overflow whenever either of those is updated.

The interrupt-enable bit is controlled by dedicated set and clear commands, an interrupt-entry strobe that clears it in hardware, and a return strobe that sets it again. The enable gates a vector of interrupt requests, each of which also needs its own enable bit. A one-bit copy path moves a selected bit of a register operand into the copy-storage flag, and a load path returns the operand with the selected bit replaced by that flag. A full-register write, as from a store to the register's I/O address, replaces everything else in the cycle where it occurs.

Top module: `psr_unit`

## Requirements
- R1: After synchronous reset all eight bits read 0. The bit order from bit 7 to bit 0 is interrupt enable (I), copy storage (T), half carry (H), sign (S), overflow (V), negative (N), zero (Z), carry (C).
- R2: `irq_pass[k]` is 1 only when `irq_req[k]`, `irq_en[k]` and the stored I bit are all 1; with I at 0 every output bit is 0.
- R3: `irq_take` clears I at the next clock edge and wins over a `sei` or `reti` in the same cycle; `cli` also wins over `sei` and `reti`.
- R4: `reti` or `sei` sets I to 1 and `cli` clears it, each taking effect at the next clock edge.
- R5: With `wr_en` high the register takes `wr_data` at the next edge, overriding ALU updates, bit store and all interrupt-enable commands of the same cycle.
- R6: On an ALU update only flags whose bit in `alu_mask` is 1 change; `alu_mask[5:0]` is aligned with bits H, S, V, N, Z, C. With `alu_upd` low or a zero mask the H..C flags keep their value.
- R7: Whenever the mask selects N, V or S, S is written as the new N xor the new V.
- R8: Kind 0 (add): C is the carry out of bit 7, H the carry out of bit 3, V is 1 when both operands share a sign that the result does not have, N is result bit 7 and Z is 1 only when all result bits are 0.
- R9: Kind 1 (subtract): C is the borrow into bit 7 (first operand below second), H the borrow from bit 4, V is 1 when the operands differ in sign and the result's sign differs from the first operand's, N is bit 7, Z is set for a zero result.
- R10: Kind 2 (subtract with borrow): C, H and V follow R9 with the stored C as borrow in; Z becomes 1 only if the result is 0 and Z was already 1.
- R11: Kind 3 (logic): V becomes 0, N and Z follow the result, and C and H keep their stored values even when masked in.
- R12: `bst_en` copies bit `bit_sel` of `reg_in` into T at the next edge; `bld_out` is `reg_in` with bit `bit_sel` replaced by the current T, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd | input | 1 | Apply an ALU flag update this cycle |
| alu_kind | input | 2 | Operation kind: 0 add, 1 subtract, 2 subtract with borrow, 3 logic |
| alu_mask | input | 6 | Update mask aligned with H, S, V, N, Z, C |
| op_a | input | 8 | First ALU operand |
| op_b | input | 8 | Second ALU operand |
| op_res | input | 8 | ALU result |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 8 | Full-register write data |
| sei | input | 1 | Set interrupt enable |
| cli | input | 1 | Clear interrupt enable |
| irq_take | input | 1 | Interrupt entry strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| bst_en | input | 1 | Bit store into T |
| bit_sel | input | 3 | Bit index for store and load |
| reg_in | input | 8 | Register operand for bit store and load |
| bld_out | output | 8 | Operand with selected bit replaced by T |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Individual interrupt enables |
| irq_pass | output | N_IRQ | Gated interrupt requests |
| sreg_q | output | 8 | Current register contents |

## Verification
The hardest situations are those where several writers of the interrupt-enable bit collide in one cycle, and where the zero flag of a chained subtraction depends on a value left by the previous operation. The stimulus reaches them by first loading a known register value through the full write, then raising conflicting strobes together (entry with set, clear with set, a full write with every other update) and by running subtract-with-borrow after both a set and a cleared zero flag. Flag values come from a reference model in the bench that uses widened integer arithmetic rather than bit equations.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int PSR_W  = 8;
    localparam int MASK_W = 6;

    localparam int B_I = 7;
    localparam int B_T = 6;
    localparam int B_H = 5;
    localparam int B_S = 4;
    localparam int B_V = 3;
    localparam int B_N = 2;
    localparam int B_Z = 1;
    localparam int B_C = 0;

    typedef enum logic [1:0] {
        FK_ADD   = 2'd0,
        FK_SUB   = 2'd1,
        FK_SUBC  = 2'd2,
        FK_LOGIC = 2'd3
    } flag_kind_e;

    // field order gives I at bit 7 down to C at bit 0
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } psr_t;

    // flags produced by the derivation stage (no I, T, S)
    typedef struct packed {
        logic h;
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    // carry out of an adder stage from operand and result bits
    function automatic logic add_cy(input logic a, input logic b, input logic r);
        return (a & b) | (b & ~r) | (~r & a);
    endfunction

    // borrow into a subtractor stage from operand and result bits
    function automatic logic sub_bw(input logic a, input logic b, input logic r);
        return (~a & b) | (b & r) | (r & ~a);
    endfunction

    function automatic logic add_ov(input logic a, input logic b, input logic r);
        return (a & b & ~r) | (~a & ~b & r);
    endfunction

    function automatic logic sub_ov(input logic a, input logic b, input logic r);
        return (a & ~b & ~r) | (~a & b & r);
    endfunction

endpackage

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
    import psr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_B = 3
) (
    input  flag_kind_e          kind,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   r,
    input  logic                c_cur,
    input  logic                h_cur,
    input  logic                z_cur,
    output alu_flags_t          flg
);
    localparam int MSB = DATA_W - 1;

    logic res_zero;
    assign res_zero = (r == '0);

    always_comb begin
        flg   = '0;
        flg.n = r[MSB];
        unique case (kind)
            FK_ADD: begin
                flg.c = add_cy(a[MSB], b[MSB], r[MSB]);
                flg.h = add_cy(a[HALF_B], b[HALF_B], r[HALF_B]);
                flg.v = add_ov(a[MSB], b[MSB], r[MSB]);
                flg.z = res_zero;
            end
            FK_SUB: begin
                flg.c = sub_bw(a[MSB], b[MSB], r[MSB]);
                flg.h = sub_bw(a[HALF_B], b[HALF_B], r[HALF_B]);
                flg.v = sub_ov(a[MSB], b[MSB], r[MSB]);
                flg.z = res_zero;
            end
            FK_SUBC: begin
                flg.c = sub_bw(a[MSB], b[MSB], r[MSB]);
                flg.h = sub_bw(a[HALF_B], b[HALF_B], r[HALF_B]);
                flg.v = sub_ov(a[MSB], b[MSB], r[MSB]);
                flg.z = res_zero & z_cur;
            end
            FK_LOGIC: begin
                flg.c = c_cur;
                flg.h = h_cur;
                flg.v = 1'b0;
                flg.z = res_zero;
            end
            default: flg = '0;
        endcase
    end

endmodule

// File: rtl/psr_bit_xfer.sv
module psr_bit_xfer #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] reg_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic              t_cur,
    output logic              bit_val,
    output logic [DATA_W-1:0] ld_out
);
    assign bit_val = reg_in[sel];

    for (genvar k = 0; k < DATA_W; k++) begin : g_ld
        assign ld_out[k] = (sel == SEL_W'(k)) ? t_cur : reg_in[k];
    end

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int N_IRQ = 8
) (
    input  logic             glob_en,
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] en,
    output logic [N_IRQ-1:0] pass
);
    for (genvar k = 0; k < N_IRQ; k++) begin : g_line
        assign pass[k] = glob_en & en[k] & req[k];
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alu_upd,
    input  logic [1:0]       alu_kind,
    input  logic [5:0]       alu_mask,
    input  logic [7:0]       op_a,
    input  logic [7:0]       op_b,
    input  logic [7:0]       op_res,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             sei,
    input  logic             cli,
    input  logic             irq_take,
    input  logic             reti,
    input  logic             bst_en,
    input  logic [2:0]       bit_sel,
    input  logic [7:0]       reg_in,
    output logic [7:0]       bld_out,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic [N_IRQ-1:0] irq_pass,
    output logic [7:0]       sreg_q
);
    psr_t       cur_q;
    psr_t       nxt;
    alu_flags_t flg;
    logic       st_bit;
    flag_kind_e kind;
    logic       sign_upd;

    assign kind = flag_kind_e'(alu_kind);

    psr_flag_calc #(.DATA_W(PSR_W), .HALF_B(3)) u_calc (
        .kind  (kind),
        .a     (op_a),
        .b     (op_b),
        .r     (op_res),
        .c_cur (cur_q.c),
        .h_cur (cur_q.h),
        .z_cur (cur_q.z),
        .flg   (flg)
    );

    psr_bit_xfer #(.DATA_W(PSR_W)) u_xfer (
        .reg_in  (reg_in),
        .sel     (bit_sel),
        .t_cur   (cur_q.t),
        .bit_val (st_bit),
        .ld_out  (bld_out)
    );

    psr_irq_gate #(.N_IRQ(N_IRQ)) u_gate (
        .glob_en (cur_q.i),
        .req     (irq_req),
        .en      (irq_en),
        .pass    (irq_pass)
    );

    assign sign_upd = alu_mask[B_N] | alu_mask[B_V] | alu_mask[B_S];

    always_comb begin
        nxt = cur_q;
        if (alu_upd) begin
            if (alu_mask[B_H]) nxt.h = flg.h;
            if (alu_mask[B_V]) nxt.v = flg.v;
            if (alu_mask[B_N]) nxt.n = flg.n;
            if (alu_mask[B_Z]) nxt.z = flg.z;
            if (alu_mask[B_C]) nxt.c = flg.c;
            if (sign_upd)      nxt.s = nxt.n ^ nxt.v;
        end
        if (bst_en) nxt.t = st_bit;
        // enable bit: entry, then clear, then set/return
        if (irq_take)         nxt.i = 1'b0;
        else if (cli)         nxt.i = 1'b0;
        else if (sei || reti) nxt.i = 1'b1;
        if (wr_en) nxt = psr_t'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign sreg_q = cur_q;

endmodule

// File: rtl/psr_check.sv
module psr_check #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             alu_upd,
    input logic [5:0]       alu_mask,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             sei,
    input logic             cli,
    input logic             irq_take,
    input logic             reti,
    input logic             bst_en,
    input logic [2:0]       bit_sel,
    input logic [7:0]       reg_in,
    input logic [N_IRQ-1:0] irq_pass,
    input logic [7:0]       sreg_q
);
    p_gate_off_r2: assert property (@(posedge clk) disable iff (rst)
        !sreg_q[7] |-> (irq_pass == '0));

    p_take_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !wr_en) |=> !sreg_q[7]);

    p_reti_sets_r4: assert property (@(posedge clk) disable iff (rst)
        ((reti || sei) && !irq_take && !cli && !wr_en) |=> sreg_q[7]);

    p_write_wins_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sreg_q == $past(wr_data)));

    p_hold_flags_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (!alu_upd || alu_mask == 6'd0)) |=> (sreg_q[5:0] == $past(sreg_q[5:0])));

    p_sign_xor_r7: assert property (@(posedge clk) disable iff (rst)
        (alu_upd && !wr_en && (alu_mask[2] || alu_mask[3])) |=> (sreg_q[4] == (sreg_q[2] ^ sreg_q[3])));

    p_bit_store_r12: assert property (@(posedge clk) disable iff (rst)
        (bst_en && !wr_en) |=> (sreg_q[6] == $past(reg_in[bit_sel])));

endmodule

bind psr_unit psr_check #(.N_IRQ(N_IRQ)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .alu_upd  (alu_upd),
    .alu_mask (alu_mask),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sei      (sei),
    .cli      (cli),
    .irq_take (irq_take),
    .reti     (reti),
    .bst_en   (bst_en),
    .bit_sel  (bit_sel),
    .reg_in   (reg_in),
    .irq_pass (irq_pass),
    .sreg_q   (sreg_q)
);

// File: tb/sim_psr_unit.sv
module sim_psr_unit;
    localparam int NI = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          alu_upd;
    logic [1:0]    alu_kind;
    logic [5:0]    alu_mask;
    logic [7:0]    op_a, op_b, op_res;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic          sei, cli, irq_take, reti, bst_en;
    logic [2:0]    bit_sel;
    logic [7:0]    reg_in;
    logic [7:0]    bld_out;
    logic [NI-1:0] irq_req, irq_en, irq_pass;
    logic [7:0]    sreg_q;

    int   n_chk = 0;
    int   n_bad = 0;
    logic done  = 1'b0;
    logic [7:0] exp;

    always #2 clk = ~clk;

    psr_unit #(.N_IRQ(NI)) u0 (
        .clk(clk), .rst(rst), .alu_upd(alu_upd), .alu_kind(alu_kind),
        .alu_mask(alu_mask), .op_a(op_a), .op_b(op_b), .op_res(op_res),
        .wr_en(wr_en), .wr_data(wr_data), .sei(sei), .cli(cli),
        .irq_take(irq_take), .reti(reti), .bst_en(bst_en), .bit_sel(bit_sel),
        .reg_in(reg_in), .bld_out(bld_out), .irq_req(irq_req), .irq_en(irq_en),
        .irq_pass(irq_pass), .sreg_q(sreg_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
        n_chk++;
        if (act !== want) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, want);
        end
    endtask

    task automatic quiet();
        alu_upd = 0; alu_kind = 0; alu_mask = 0; op_a = 0; op_b = 0; op_res = 0;
        wr_en = 0; wr_data = 0; sei = 0; cli = 0; irq_take = 0; reti = 0;
        bst_en = 0; bit_sel = 0; reg_in = 0;
    endtask

    // inputs already set; cross one rising edge, sample at falling edge
    task automatic step();
        @(negedge clk);
        quiet();
    endtask

    // independent reference for one masked flag update
    function automatic logic [7:0] ref_upd(input logic [1:0] k, input logic [7:0] a,
        input logic [7:0] b, input logic [7:0] r, input logic [5:0] m, input logic [7:0] cur);
        logic [7:0] nx;
        int cin;
        logic c, h, v, n, z;
        nx = cur;
        cin = (k == 2) ? int'(cur[0]) : 0;
        n = r[7];
        z = (r == 0);
        if (k == 0) begin
            c = (int'(a) + int'(b)) > 255;
            h = (int'(a[3:0]) + int'(b[3:0])) > 15;
            v = (a[7] == b[7]) && (r[7] != a[7]);
        end else if (k == 3) begin
            c = cur[0]; h = cur[5]; v = 0;
        end else begin
            c = int'(a) < int'(b) + cin;
            h = int'(a[3:0]) < int'(b[3:0]) + cin;
            v = (a[7] != b[7]) && (r[7] != a[7]);
            if (k == 2) z = z && cur[1];
        end
        if (m[5]) nx[5] = h;
        if (m[3]) nx[3] = v;
        if (m[2]) nx[2] = n;
        if (m[1]) nx[1] = z;
        if (m[0]) nx[0] = c;
        if (m[2] || m[3] || m[4]) nx[4] = nx[2] ^ nx[3];
        return nx;
    endfunction

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wr_data = d; step(); exp = d;
    endtask

    task automatic alu(input string req, input logic [1:0] k, input logic [7:0] a,
        input logic [7:0] b, input logic [7:0] r, input logic [5:0] m);
        alu_upd = 1; alu_kind = k; op_a = a; op_b = b; op_res = r; alu_mask = m;
        exp = ref_upd(k, a, b, r, m, exp);
        step();
        chk(req, sreg_q, exp);
    endtask

    task automatic t_reset();
        irq_req = '1; irq_en = '1;
        rst = 1; quiet();
        repeat (2) @(negedge clk);
        rst = 0;
        chk("R1 reset value", sreg_q, 8'h00);
        chk("R1 gate closed at reset", irq_pass, 0);
        @(negedge clk);
        chk("R1 still zero", sreg_q, 8'h00);
        exp = 0;
    endtask

    task automatic t_layout();
        irq_req = 8'hFF; irq_en = 8'h3C;
        wr(8'h80);
        chk("R1 I at bit 7", irq_pass, 8'h3C);
        wr(8'h7F);
        chk("R1 other bits not I", irq_pass, 0);
        chk("R5 write value", sreg_q, 8'h7F);
    endtask

    task automatic t_gate();
        wr(8'h00);
        irq_req = 8'hFF; irq_en = 8'h0F;
        #1 chk("R2 I low blocks", irq_pass, 0);
        sei = 1; step();
        chk("R4 sei sets I", sreg_q[7], 1);
        chk("R2 pass enabled lines", irq_pass, 8'h0F);
        irq_req = 8'h5A; #1
        chk("R2 req and en", irq_pass, 8'h0A);
        irq_en = 8'h00; #1
        chk("R2 individual enable off", irq_pass, 0);
    endtask

    task automatic t_take();
        wr(8'h80);
        irq_take = 1; sei = 1; step();
        chk("R3 entry beats sei", sreg_q, 8'h00);
        wr(8'h80);
        irq_take = 1; reti = 1; step();
        chk("R3 entry beats reti", sreg_q, 8'h00);
        wr(8'h00);
        cli = 1; sei = 1; step();
        chk("R3 cli beats sei", sreg_q, 8'h00);
    endtask

    task automatic t_reti();
        wr(8'h21);
        reti = 1; step();
        chk("R4 reti sets I", sreg_q, 8'hA1);
        cli = 1; step();
        chk("R4 cli clears I", sreg_q, 8'h21);
        sei = 1; step();
        chk("R4 sei sets I", sreg_q, 8'hA1);
    endtask

    task automatic t_override();
        wr(8'h00);
        wr_en = 1; wr_data = 8'h5A;
        alu_upd = 1; alu_kind = 0; alu_mask = 6'h3F; op_a = 8'hFF; op_b = 8'h01; op_res = 8'h00;
        sei = 1; irq_take = 1; bst_en = 1; reg_in = 8'h00; bit_sel = 3'd6;
        step();
        chk("R5 write overrides all", sreg_q, 8'h5A);
        wr_en = 1; wr_data = 8'h00; sei = 1; reti = 1; step();
        chk("R5 write beats sei", sreg_q, 8'h00);
        exp = 8'h00;
    endtask

    task automatic t_add();
        wr(8'h00);
        alu("R8 add 7F+01", 2'd0, 8'h7F, 8'h01, 8'h80, 6'h3F);
        chk("R8 add 7F+01 known", sreg_q, 8'h2C);
        alu("R8 add FF+01", 2'd0, 8'hFF, 8'h01, 8'h00, 6'h3F);
        chk("R8 add FF+01 known", sreg_q, 8'h23);
        alu("R8 add 80+80", 2'd0, 8'h80, 8'h80, 8'h00, 6'h3F);
        alu("R8 add 12+34", 2'd0, 8'h12, 8'h34, 8'h46, 6'h3F);
    endtask

    task automatic t_sub();
        wr(8'h00);
        alu("R9 sub 10-20", 2'd1, 8'h10, 8'h20, 8'hF0, 6'h3F);
        chk("R9 sub 10-20 known", sreg_q, 8'h15);
        alu("R9 sub 80-01", 2'd1, 8'h80, 8'h01, 8'h7F, 6'h3F);
        chk("R9 sub 80-01 known", sreg_q, 8'h38);
        alu("R9 sub 33-33", 2'd1, 8'h33, 8'h33, 8'h00, 6'h3F);
    endtask

    task automatic t_subc();
        wr(8'h00);
        alu("R10 subc zero with Z clear", 2'd2, 8'h05, 8'h05, 8'h00, 6'h3F);
        chk("R10 Z stays clear", sreg_q[1], 0);
        wr(8'h02);
        alu("R10 subc zero with Z set", 2'd2, 8'h05, 8'h05, 8'h00, 6'h3F);
        chk("R10 Z kept", sreg_q[1], 1);
        wr(8'h03);
        alu("R10 subc with borrow in", 2'd2, 8'h00, 8'h00, 8'hFF, 6'h3F);
        chk("R10 Z cleared by nonzero", sreg_q[1], 0);
    endtask

    task automatic t_logic();
        wr(8'h29);
        alu("R11 logic zero result", 2'd3, 8'hF0, 8'h0F, 8'h00, 6'h3F);
        chk("R11 logic known", sreg_q, 8'h23);
        wr(8'h08);
        alu("R11 logic negative", 2'd3, 8'hF0, 8'hFF, 8'hF0, 6'h3F);
        chk("R11 logic negative known", sreg_q, 8'h14);
    endtask

    task automatic t_mask();
        wr(8'hFF);
        alu("R6 only Z updated", 2'd0, 8'h01, 8'h01, 8'h02, 6'h02);
        chk("R6 only Z known", sreg_q, 8'hFD);
        alu("R6 zero mask", 2'd1, 8'h00, 8'h01, 8'hFF, 6'h00);
        chk("R6 zero mask known", sreg_q, 8'hFD);
        op_a = 8'h00; op_b = 8'h01; op_res = 8'hFF; alu_mask = 6'h3F; alu_kind = 1;
        step();
        chk("R6 alu_upd low ignored", sreg_q, 8'hFD);
        wr(8'h00);
        alu("R7 V only updates S", 2'd1, 8'h80, 8'h01, 8'h7F, 6'h08);
        chk("R7 S from V", sreg_q, 8'h18);
        alu("R7 N only updates S", 2'd3, 8'h80, 8'h80, 8'h80, 6'h04);
        chk("R7 S from N xor V", sreg_q, 8'h0C);
    endtask

    task automatic t_bits();
        wr(8'h00);
        bst_en = 1; reg_in = 8'h08; bit_sel = 3'd3; step();
        chk("R12 store 1 into T", sreg_q, 8'h40);
        reg_in = 8'h00; bit_sel = 3'd5; #1
        chk("R12 load T into bit 5", bld_out, 8'h20);
        bst_en = 1; reg_in = 8'hFE; bit_sel = 3'd0; step();
        chk("R12 store 0 into T", sreg_q, 8'h00);
        reg_in = 8'hFF; bit_sel = 3'd7; #1
        chk("R12 load T into bit 7", bld_out, 8'h7F);
    endtask

    initial begin
        quiet();
        irq_req = 0; irq_en = 0; rst = 1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_gate();
        t_take();
        t_reti();
        t_override();
        t_add();
        t_sub();
        t_subc();
        t_logic();
        t_mask();
        t_bits();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule